// File: doc/BRIEF.md
# Second-Aligned Sample Time Base with PPS Phase Monitor

This block gives every converter sample an absolute time label and watches how well the local clock tracks the once-per-second pulse from the satellite receiver. It runs on the disciplined reference clock, nominally 10 MHz. The time of day in whole seconds arrives from the receiver's message handler. That value is held until the first rising edge of the pulse after reset. On that edge the block aligns itself once. From then on it counts sample ticks and clock cycles on its own, and later pulse edges never realign the count.

Each later pulse edge is compared against the free-running cycle count, and the signed offset is reported. Lock is declared after a run of consecutive edges that fall inside the tolerance window. Two further conditions raise sticky flags. One is a pulse that fails to appear within one second plus the tolerance. The other is lock not reached within the allowed number of seconds after alignment.

The seconds load uses a valid/ready handshake. `ld_ready` is high only before alignment, so a load offered later is never accepted and leaves no trace. The stamp stream has a valid strobe and no ready: samples cannot wait, so the consumer must take each stamp in the cycle it appears.

Top module: `pps_timebase`

## Requirements
- R1: After reset, `synced`, `stamp_valid`, `locked`, `pps_missing` and `timed_out` are 0, `phase_err` is 0 and `ld_ready` is 1.
- R2: While `ld_ready` is 1, a cycle with `ld_valid` high stores `ld_sec`, and the latest accepted value wins. After alignment `ld_ready` is 0, and a later `ld_valid` has no effect on the stamps.
- R3: The first rising edge of `pps_in` after reset aligns the block: `synced` goes to 1, and the next stamp carries the stored seconds value with index 0. Later edges leave the stamp sequence unchanged.
- R4: Before alignment, `smp_tick` produces no stamp.
- R5: After alignment, a `smp_tick` high in a cycle gives `stamp_valid` high one cycle later, with the current seconds and index. The index then advances by one.
- R6: The index counts 0 to SMP_PER_SEC-1. After the stamp with the last index, the index returns to 0 and the seconds value increases by one.
- R7: `pps_in` passes through a two-flop synchroniser, and a level held high for several cycles counts as a single edge. At each edge after alignment, `phase_err` shows the signed offset in cycles between the edge and the free-running one-second count. An edge exactly CLK_PER_SEC cycles after the previous edge on the count reads 0, and a late edge reads positive.
- R8: An edge with |phase_err| <= TOL_CYC is in-window. `locked` rises at the LOCK_SECS-th consecutive in-window edge. An out-of-window edge clears `locked` and the run count.
- R9: If more than CLK_PER_SEC+TOL_CYC cycles pass after an edge with no new edge, `pps_missing` is set. It stays set until reset, and it clears `locked` and the run count.
- R10: If `locked` has never been 1 when TIMEOUT_SECS seconds of the free-running count have elapsed since alignment, `timed_out` is set. It stays set until reset. Once lock has been reached at least once, it is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Disciplined reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_in | input | 1 | Raw pulse-per-second, asynchronous |
| smp_tick | input | 1 | One-cycle sample rollover strobe |
| ld_valid | input | 1 | Seconds load offered |
| ld_ready | output | 1 | Seconds load accepted (high before alignment) |
| ld_sec | input | SEC_W | Seconds value from the time message |
| synced | output | 1 | Alignment to the first edge done |
| stamp_valid | output | 1 | Stamp present this cycle |
| stamp_sec | output | SEC_W | Seconds part of the stamp |
| stamp_idx | output | IDX_W | Sample index within the second |
| phase_err | output | PHW | Signed offset in cycles at the last edge |
| locked | output | 1 | Consecutive in-window run reached |
| pps_missing | output | 1 | Sticky: a pulse failed to arrive |
| timed_out | output | 1 | Sticky: no lock within the time limit |

## Verification
The pulse spacing is driven in four ways, each aimed at a different part of the tracking logic:
- Exact one-second spacing shows that lock builds over the required number of edges.
- Offsets of exactly plus or minus the tolerance show that the window edges count as inside.
- An offset one cycle beyond the tolerance separates the missing-pulse test, which works on the gap from the previous edge, from the window test, which works on the accumulated offset.
- A random walk of offsets inside the window checks that accumulated phase is reported, not the gap alone.

Random sample ticks cover index wrap and stamp continuity across pulse edges, both before and after alignment. A second run with a constant out-of-window offset exercises the timeout.

// File: rtl/ppsmon_pkg.sv
package ppsmon_pkg;
  // Width of the seconds field carried by every stamp.
  localparam int SEC_W_DEF = 32;
  // Default count of synchroniser flops on the pulse input.
  localparam int SYNC_FLOPS = 2;
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int STAGES = ppsmon_pkg::SYNC_FLOPS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_raw,
  output logic pps_rise
);
  // chain[STAGES-1:0] is the synchroniser, chain[STAGES] the edge delay.
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], pps_raw};
  end

  assign pps_rise = chain[STAGES-1] & ~chain[STAGES];

  // R7
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pps_rise |=> !pps_rise);
endmodule

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int SMP_PER_SEC = 12800,
  parameter int SEC_W = ppsmon_pkg::SEC_W_DEF,
  localparam int IDX_W = $clog2(SMP_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEC_W-1:0] seed_sec,
  input  logic             running,
  input  logic             tick,
  output logic             stamp_valid,
  output logic [SEC_W-1:0] stamp_sec,
  output logic [IDX_W-1:0] stamp_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SMP_PER_SEC - 1);

  logic [IDX_W-1:0] idx;
  logic [SEC_W-1:0] sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      sec <= '0;
      stamp_valid <= 1'b0;
      stamp_sec <= '0;
      stamp_idx <= '0;
    end else begin
      stamp_valid <= 1'b0;
      if (start) begin
        idx <= '0;
        sec <= seed_sec;
      end else if (running && tick) begin
        stamp_valid <= 1'b1;
        stamp_sec <= sec;
        stamp_idx <= idx;
        if (idx == LAST) begin
          idx <= '0;
          sec <= sec + 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_valid |-> (stamp_idx <= LAST));
  // R5
  stamp_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_valid |-> $past(tick && running));
endmodule

// File: rtl/phase_monitor.sv
module phase_monitor #(
  parameter int CLK_PER_SEC = 10_000_000,
  parameter int TOL_CYC = 2,
  parameter int LOCK_SECS = 4,
  parameter int TIMEOUT_SECS = 30,
  localparam int PHW = $clog2(CLK_PER_SEC) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  running,
  input  logic                  edge_in,
  output logic signed [PHW-1:0] phase_err,
  output logic                  locked,
  output logic                  pps_missing,
  output logic                  timed_out
);
  localparam int CW = $clog2(CLK_PER_SEC);
  localparam int GW = $clog2(CLK_PER_SEC + TOL_CYC + 2);
  localparam int LW = $clog2(LOCK_SECS + 1);
  localparam int TW = $clog2(TIMEOUT_SECS + 1);
  localparam logic [CW-1:0] LASTC = CW'(CLK_PER_SEC - 1);
  localparam logic [CW-1:0] HALF = CW'(CLK_PER_SEC / 2);
  localparam logic [GW-1:0] MISS_AT = GW'(CLK_PER_SEC + TOL_CYC);
  localparam logic [GW-1:0] GMAX = GW'(CLK_PER_SEC + TOL_CYC + 1);
  localparam logic signed [PHW-1:0] TOL_S = PHW'(TOL_CYC);
  localparam logic [LW-1:0] LFULL = LW'(LOCK_SECS);
  localparam logic [TW-1:0] TFULL = TW'(TIMEOUT_SECS);

  logic [CW-1:0] cyc, cyc_nxt;
  logic [GW-1:0] gap;
  logic [LW-1:0] run_cnt;
  logic [TW-1:0] secs;
  logic ever_locked;
  logic signed [PHW-1:0] err;
  logic [PHW-1:0] ext;
  logic in_win;

  always_comb begin
    cyc_nxt = (cyc == LASTC) ? '0 : cyc + 1'b1;
    ext = {1'b0, cyc_nxt};
    if (cyc_nxt > HALF) err = $signed(ext - PHW'(CLK_PER_SEC));
    else                err = $signed(ext);
    in_win = (err <= TOL_S) && (err >= -TOL_S);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
      gap <= '0;
      run_cnt <= '0;
      secs <= '0;
      ever_locked <= 1'b0;
      locked <= 1'b0;
      phase_err <= '0;
      pps_missing <= 1'b0;
      timed_out <= 1'b0;
    end else if (start) begin
      cyc <= '0;
      gap <= GW'(1);
      run_cnt <= '0;
      secs <= '0;
      ever_locked <= 1'b0;
      locked <= 1'b0;
      phase_err <= '0;
    end else if (running) begin
      cyc <= cyc_nxt;
      if (cyc == LASTC) begin
        if (secs != TFULL) secs <= secs + 1'b1;
        if (!ever_locked && (int'(secs) + 1 >= TIMEOUT_SECS)) timed_out <= 1'b1;
      end
      if (edge_in) begin
        gap <= GW'(1);
        phase_err <= err;
        if (in_win) begin
          if (run_cnt != LFULL) run_cnt <= run_cnt + 1'b1;
          if (int'(run_cnt) + 1 >= LOCK_SECS) begin
            locked <= 1'b1;
            ever_locked <= 1'b1;
          end
        end else begin
          run_cnt <= '0;
          locked <= 1'b0;
        end
      end else begin
        if (gap != GMAX) gap <= gap + 1'b1;
        if (gap == MISS_AT) begin
          pps_missing <= 1'b1;
          run_cnt <= '0;
          locked <= 1'b0;
        end
      end
    end
  end

  // R8
  lock_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(edge_in));
  // R8
  lock_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> ((phase_err <= TOL_S) && (phase_err >= -TOL_S)));
  // R9
  miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pps_missing) |-> pps_missing);
  // R9
  miss_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pps_missing) |-> !locked);
  // R10
  tmo_without_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> !$past(ever_locked));
  // R10
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(timed_out) |-> timed_out);
endmodule

// File: rtl/pps_timebase.sv
module pps_timebase #(
  parameter int CLK_PER_SEC = 10_000_000,
  parameter int SMP_PER_SEC = 12800,
  parameter int TOL_CYC = 2,
  parameter int LOCK_SECS = 4,
  parameter int TIMEOUT_SECS = 30,
  parameter int SEC_W = ppsmon_pkg::SEC_W_DEF,
  localparam int IDX_W = $clog2(SMP_PER_SEC),
  localparam int PHW = $clog2(CLK_PER_SEC) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pps_in,
  input  logic                  smp_tick,
  input  logic                  ld_valid,
  output logic                  ld_ready,
  input  logic [SEC_W-1:0]      ld_sec,
  output logic                  synced,
  output logic                  stamp_valid,
  output logic [SEC_W-1:0]      stamp_sec,
  output logic [IDX_W-1:0]      stamp_idx,
  output logic signed [PHW-1:0] phase_err,
  output logic                  locked,
  output logic                  pps_missing,
  output logic                  timed_out
);
  logic pps_rise, first_edge, later_edge, ld_take;
  logic [SEC_W-1:0] pend_sec, seed;

  pps_edge_sync #(.STAGES(ppsmon_pkg::SYNC_FLOPS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pps_raw(pps_in), .pps_rise(pps_rise));

  assign ld_ready   = ~synced;
  assign ld_take    = ld_valid & ld_ready;
  assign first_edge = pps_rise & ~synced;
  assign later_edge = pps_rise & synced;
  assign seed       = ld_take ? ld_sec : pend_sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced <= 1'b0;
      pend_sec <= '0;
    end else begin
      if (first_edge) synced <= 1'b1;
      if (ld_take) pend_sec <= ld_sec;
    end
  end

  stamp_counter #(.SMP_PER_SEC(SMP_PER_SEC), .SEC_W(SEC_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .start(first_edge), .seed_sec(seed),
    .running(synced), .tick(smp_tick), .stamp_valid(stamp_valid),
    .stamp_sec(stamp_sec), .stamp_idx(stamp_idx));

  phase_monitor #(.CLK_PER_SEC(CLK_PER_SEC), .TOL_CYC(TOL_CYC),
    .LOCK_SECS(LOCK_SECS), .TIMEOUT_SECS(TIMEOUT_SECS)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(first_edge), .running(synced),
    .edge_in(later_edge), .phase_err(phase_err), .locked(locked),
    .pps_missing(pps_missing), .timed_out(timed_out));

  // R3
  sync_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(synced) |-> synced);
  // R4
  no_stamp_unsynced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(synced) |-> !stamp_valid);
endmodule

// File: tb/sim_pps_timebase.sv
module sim_pps_timebase;
  localparam int CPS = 100;
  localparam int SPS = 4;
  localparam int TOL = 2;
  localparam int LOCKN = 3;
  localparam int TMO = 6;
  localparam int PHW = $clog2(CPS) + 1;
  localparam int IDX_W = $clog2(SPS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pps_in = 1'b0, smp_tick = 1'b0, ld_valid = 1'b0;
  logic [31:0] ld_sec = '0;
  logic ld_ready, synced, stamp_valid, locked, pps_missing, timed_out;
  logic [31:0] stamp_sec;
  logic [IDX_W-1:0] stamp_idx;
  logic signed [PHW-1:0] phase_err;

  always #2 clk = ~clk;

  pps_timebase #(.CLK_PER_SEC(CPS), .SMP_PER_SEC(SPS), .TOL_CYC(TOL),
    .LOCK_SECS(LOCKN), .TIMEOUT_SECS(TMO), .SEC_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .smp_tick(smp_tick),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_sec(ld_sec),
    .synced(synced), .stamp_valid(stamp_valid), .stamp_sec(stamp_sec),
    .stamp_idx(stamp_idx), .phase_err(phase_err), .locked(locked),
    .pps_missing(pps_missing), .timed_out(timed_out));

  int n_chk = 0, n_bad = 0;
  bit m_synced, m_locked, m_missing, m_ever, m_tmo;
  int m_sec, m_idx, cum, lcnt, k, prev_len;
  int dev[32];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int next_idx(input int i);
    return (i == SPS - 1) ? 0 : i + 1;
  endfunction

  function automatic bit in_window(input int c);
    return (c <= TOL) && (c >= -TOL);
  endfunction

  task automatic model_reset();
    m_synced = 0; m_locked = 0; m_missing = 0; m_ever = 0; m_tmo = 0;
    m_sec = 0; m_idx = 0; cum = 0; lcnt = 0; k = 0; prev_len = CPS;
  endtask

  task automatic step(input logic p, input logic t);
    pps_in = p;
    smp_tick = t;
    @(posedge clk);
    #1;
    if (t) begin
      if (m_synced) begin
        chk(stamp_valid == 1'b1, "R5 stamp_valid", stamp_valid, 1);
        chk(stamp_sec == 32'(m_sec), (m_idx == SPS - 1) ? "R6 R3 stamp_sec" : "R5 R3 stamp_sec", stamp_sec, m_sec);
        chk(int'(stamp_idx) == m_idx, "R6 stamp_idx", stamp_idx, m_idx);
        if (m_idx == SPS - 1) m_sec++;
        m_idx = next_idx(m_idx);
      end else begin
        chk(stamp_valid == 1'b0, "R4 stamp before sync", stamp_valid, 0);
      end
    end
  endtask

  task automatic edge_check(input bit first);
    if (first) begin
      m_synced = 1;
      m_idx = 0;
      chk(synced == 1'b1, "R3 synced", synced, 1);
      chk(ld_ready == 1'b0, "R2 ld_ready after sync", ld_ready, 0);
      chk(locked == 1'b0, "R8 locked at sync", locked, 0);
    end else begin
      int d;
      d = prev_len - CPS;
      k++;
      if (d > TOL) begin m_missing = 1; lcnt = 0; m_locked = 0; end
      cum += d;
      if (!m_ever && ((k * CPS + cum) / CPS >= TMO)) m_tmo = 1;
      if (in_window(cum)) begin
        if (lcnt < LOCKN) lcnt++;
        if (lcnt >= LOCKN) begin m_locked = 1; m_ever = 1; end
      end else begin
        lcnt = 0; m_locked = 0;
      end
      chk(int'(phase_err) == cum, "R7 phase_err", phase_err, cum);
      chk(locked == m_locked, "R8 locked", locked, m_locked);
      chk(pps_missing == m_missing, "R9 pps_missing", pps_missing, m_missing);
      chk(timed_out == m_tmo, "R10 timed_out", timed_out, m_tmo);
    end
  endtask

  // One pulse period: pulse high at offsets 10..14, edge visible after offset 12.
  task automatic second(input int len, input bit first, input bit ticks_on, input bit do_ld);
    for (int i = 0; i < len; i++) begin
      bit t;
      t = ticks_on && !(first && i <= 13) && ($urandom % 12 == 0);
      if (do_ld && i == 30) begin ld_valid = 1'b1; ld_sec = 32'd5; end
      step((i >= 10 && i < 15), t);
      if (do_ld && i == 30) begin
        chk(ld_ready == 1'b0, "R2 load refused", ld_ready, 0);
        ld_valid = 1'b0;
      end
      if (i == 12) edge_check(first);
    end
    prev_len = len;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pps_in = 1'b0; smp_tick = 1'b0; ld_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic load(input int v);
    ld_valid = 1'b1;
    ld_sec = 32'(v);
    step(1'b0, 1'b0);
    ld_valid = 1'b0;
  endtask

  initial begin
    int n, c, nc, sd;
    sd = $urandom(32'd7);
    do_reset();
    chk(synced == 1'b0 && locked == 1'b0 && pps_missing == 1'b0 && timed_out == 1'b0,
        "R1 flags after reset", {synced, locked, pps_missing, timed_out}, 0);
    chk(stamp_valid == 1'b0, "R1 stamp_valid", stamp_valid, 0);
    chk(phase_err == '0, "R1 phase_err", phase_err, 0);
    chk(ld_ready == 1'b1, "R1 ld_ready", ld_ready, 1);

    // R2 two loads before sync: the later one wins. R4 ticks before sync.
    load(1000);
    load(1234);
    for (int i = 0; i < 40; i++) step(1'b0, ($urandom % 3 == 0));
    m_sec = 1234;

    // Directed deviations then an in-window random walk of accumulated phase.
    n = 0;
    dev[n++] = 0;
    dev[n++] = 0; dev[n++] = 0; dev[n++] = 0;
    dev[n++] = 2; dev[n++] = -2;
    dev[n++] = 3; dev[n++] = -3;
    dev[n++] = 0; dev[n++] = 0; dev[n++] = 0;
    c = 0;
    for (int j = 0; j < 7; j++) begin
      nc = int'($urandom % 5) - 2;
      dev[n++] = nc - c;
      c = nc;
    end
    for (int j = 0; j < n; j++) begin
      int len;
      len = (j == n - 1) ? 20 : CPS + dev[j + 1];
      second(len, (j == 0), 1'b1, (j == 4));
    end

    // Timeout run: constant out-of-window offset keeps lock away.
    do_reset();
    load(77);
    m_sec = 77;
    n = 0;
    dev[n++] = 0;
    dev[n++] = 3;
    for (int j = 0; j < TMO + 1; j++) dev[n++] = 0;
    for (int j = 0; j < n; j++) begin
      int len;
      len = (j == n - 1) ? 20 : CPS + dev[j + 1];
      second(len, (j == 0), 1'b1, 1'b0);
    end
    chk(timed_out == 1'b1, "R10 timeout raised", timed_out, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule